// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Register

This block gathers three single-cycle event pulses (periodic tick, alarm match, update finished) into sticky flags and presents them, together with a summary interrupt bit, as one read-only status byte. Each flag is qualified by its own enable bit. When any qualified flag is set, the block asserts an output-enable that pulls a shared active-low, open-drain interrupt line low. Otherwise the line is left floating.

Software reads the byte to learn which events occurred. The read itself clears every flag. The register keeps its value for the whole read, so the host sees a consistent byte. An event that lands during the read is parked and merged into the flags once the read is over, so no event is lost. The enable bits are kept in the block as copies of the control-register inputs. A copy reloads whenever its input changes level. Reset clears all copies. Raising the freeze (SET) input clears the update-ended enable.

Top module: `irq_status_reg`

## Requirements
- R1: The status byte carries the summary bit at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update-ended flag at bit 4. Bits 3 to 0 always read 0.
- R2: An event pulse sets its flag at the next clock edge, whatever its enable is. The flag then stays set until it is cleared.
- R3: The summary bit is 1 exactly when at least one flag is set together with its held enable. `irq_oe` equals the summary bit.
- R4: If an enable input rises while its flag is already pending, `irq_oe` is asserted from the clock edge that loads the enable.
- R5: A read lasts while `sel` is 1 and `rd_n` is 0. At the first clock edge after the read ends, all flags are cleared, and so is the summary bit.
- R6: An event that arrives during a read is held. It appears in its flag at the edge that ends the read.
- R7: The flag bits do not change while a read is in progress.
- R8: Driving `rd_n` low while `sel` is 0 neither clears nor freezes the flags.
- R9: An active-low `rst_n` clears all flags and all held enables and releases `irq_oe`. After reset, an enable copy reloads only when its input next changes level.
- R10: A rising edge on `set_mode` clears the held update-ended enable at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_periodic | input | 1 | Periodic tick event pulse |
| evt_alarm | input | 1 | Alarm match event pulse |
| evt_update | input | 1 | Update-finished event pulse |
| en_periodic | input | 1 | Periodic interrupt enable from control register |
| en_alarm | input | 1 | Alarm interrupt enable from control register |
| en_update | input | 1 | Update-ended interrupt enable from control register |
| set_mode | input | 1 | Freeze bit; rising edge clears update-ended enable |
| sel | input | 1 | Register select for the status byte |
| rd_n | input | 1 | Active-low read strobe |
| status_q | output | 8 | Status byte |
| irq_oe | output | 1 | Drive-low enable for the open-drain interrupt line |

## Verification
A flag register stuck or wrongly set shows at the status port one edge after the event that should have set it, and at `irq_oe` in the same cycle once its enable is on. A wrong pending or read-tracking state only shows at the edge that ends a read: held events are missing, or flags are cleared early or not at all. A wrong held enable shows as `irq_oe` differing from the flag pattern within one cycle of an enable change, a SET edge or a reset.

// File: rtl/irq_status_reg.sv
module irq_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_periodic,
  input  logic       evt_alarm,
  input  logic       evt_update,
  input  logic       en_periodic,
  input  logic       en_alarm,
  input  logic       en_update,
  input  logic       set_mode,
  input  logic       sel,
  input  logic       rd_n,
  output logic [7:0] status_q,
  output logic       irq_oe
);
  logic [2:0] evt, en_in, en_prev, en_q, flag_q, pend_q;
  logic       rd_act, rd_prev, set_prev, set_rise, irqf;

  assign evt      = {evt_periodic, evt_alarm, evt_update};
  assign en_in    = {en_periodic, en_alarm, en_update};
  assign rd_act   = sel & ~rd_n;
  assign set_rise = set_mode & ~set_prev;
  assign irqf     = |(flag_q & en_q);
  assign irq_oe   = irqf;
  assign status_q = {irqf, flag_q, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev  <= '1;
      en_q     <= '0;
      flag_q   <= '0;
      pend_q   <= '0;
      rd_prev  <= 1'b0;
      set_prev <= 1'b0;
    end else begin
      en_prev  <= en_in;
      set_prev <= set_mode;
      rd_prev  <= rd_act;
      for (int i = 0; i < 3; i++)
        if (en_in[i] != en_prev[i]) en_q[i] <= en_in[i];
      if (set_rise) en_q[0] <= 1'b0;
      if (rd_act) begin
        pend_q <= pend_q | evt;
      end else if (rd_prev) begin
        flag_q <= pend_q | evt;
        pend_q <= '0;
      end else begin
        flag_q <= flag_q | evt;
      end
    end
  end

  p_flags_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && rd_prev) |=> $stable(flag_q));

  p_pend_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_prev |-> (pend_q == 3'b000));

  p_event_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_act && !rd_prev && |evt) |=> ((flag_q & $past(evt)) == $past(evt)));

  p_clear_on_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_prev && !rd_act && evt == 3'b000 && pend_q == 3'b000) |=> (flag_q == 3'b000));

  p_set_drops_upd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_rise |=> !en_q[0]);
endmodule

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_periodic = 0, evt_alarm = 0, evt_update = 0;
  logic en_periodic = 0, en_alarm = 0, en_update = 0;
  logic set_mode = 0, sel = 0, rd_n = 1;
  logic [7:0] status_q;
  logic irq_oe;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_status_reg u_dut (
    .clk(clk), .rst_n(rst_n),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
    .set_mode(set_mode), .sel(sel), .rd_n(rd_n),
    .status_q(status_q), .irq_oe(irq_oe));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic set_ev(input logic [2:0] v);
    {evt_periodic, evt_alarm, evt_update} = v;
  endtask

  task automatic set_en(input logic [2:0] v);
    {en_periodic, en_alarm, en_update} = v;
  endtask

  task automatic do_read();
    sel = 1; rd_n = 0; tick(); tick();
    rd_n = 1; tick(); sel = 0;
  endtask

  function automatic logic [7:0] exp_stat(input logic [2:0] f, input logic [2:0] e);
    return {|(f & e), f, 4'b0000};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R9 reset status", status_q, 8'h00);
    check("R9 reset irq", {7'b0, irq_oe}, 8'h00);
    rst_n = 1; tick();

    // R1 R2 R3 sweep over all flag and enable patterns
    for (int e = 0; e < 8; e++) begin
      for (int v = 0; v < 8; v++) begin
        do_read();
        set_en(3'b000); tick();
        set_en(3'(e)); tick();
        set_ev(3'(v)); tick();
        set_ev(3'b000);
        check("R1 R2 R3 sweep status", status_q, exp_stat(3'(v), 3'(e)));
        check("R3 sweep irq", {7'b0, irq_oe}, {7'b0, |(3'(v) & 3'(e))});
      end
    end

    // R5 clear after read
    do_read();
    set_en(3'b000); tick();
    set_ev(3'b111); tick(); set_ev(3'b000);
    check("R5 before read", status_q, 8'h70);
    do_read();
    check("R5 after read", status_q, 8'h00);

    // R6 R7 events during read are held, flags frozen
    set_ev(3'b010); tick(); set_ev(3'b000);
    check("R2 alarm set", status_q, 8'h20);
    sel = 1; rd_n = 0; tick();
    set_ev(3'b100); tick(); set_ev(3'b000); tick();
    check("R7 frozen during read", status_q, 8'h20);
    rd_n = 1; tick(); sel = 0;
    check("R6 held event lands", status_q, 8'h40);

    // R8 strobe without select
    rd_n = 0; tick(); tick(); rd_n = 1; tick();
    check("R8 no clear without sel", status_q, 8'h40);

    // R4 enable on pending flag
    check("R4 no irq before enable", {7'b0, irq_oe}, 8'h00);
    en_periodic = 1; tick();
    check("R4 irq on enable", {7'b0, irq_oe}, 8'h01);
    check("R4 status", status_q, 8'hC0);

    // R10 SET rising clears update enable
    do_read();
    set_en(3'b001); tick();
    set_ev(3'b001); tick(); set_ev(3'b000);
    check("R10 irq before set", {7'b0, irq_oe}, 8'h01);
    set_mode = 1; tick();
    check("R10 irq after set", {7'b0, irq_oe}, 8'h00);
    check("R10 flag kept", status_q, 8'h10);
    set_mode = 0; tick();

    // R9 reset mid-run, enables stay cleared until inputs change
    set_en(3'b111); tick();
    set_ev(3'b111); tick(); set_ev(3'b000);
    check("R9 pre-reset", status_q, 8'hF0);
    rst_n = 0; #1;
    check("R9 async clear", status_q, 8'h00);
    tick(); rst_n = 1; tick();
    set_ev(3'b111); tick(); set_ev(3'b000);
    check("R9 enables cleared", {7'b0, irq_oe}, 8'h00);
    check("R9 flags set again", status_q, 8'h70);
    set_en(3'b000); tick(); set_en(3'b010); tick();
    check("R9 reload alarm enable", status_q, 8'hF0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule